// File: doc/BRIEF.md
# Head Step Tracker

This block models the head-positioning logic of a floppy drive. The controller drives four active-low inputs: drive select, step, direction and write enable. The block passes each input through a two-flop synchroniser, finds the edges of the step line, and moves a track counter one track inward or outward. The move takes effect when the step pulse ends (its rising edge), not when it begins. The current track is output as a binary number, together with an active-low track-zero indicator that is only asserted while the drive is selected.

A small state machine follows each step pulse through three states. In `ST_IDLE` it waits for a falling edge on step. In `ST_PULSE` it measures the pulse width and, on the trailing edge, decides whether the step is accepted. In `ST_HOLD` it guards the direction hold window after the pulse ends. The transitions are:
- idle to pulse on a step falling edge;
- pulse to hold on a trailing edge with enough width;
- pulse to idle on a trailing edge that is too short;
- hold to pulse on a new falling edge;
- hold to idle when the hold window runs out;
- any state to idle as soon as the drive is deselected.

A step is refused in three cases: write is active, the head is at track 0 and the direction points outward, or the head is at the last track and the direction points inward. The block also raises one-cycle flags for three timing faults: a step pulse that is too short, trailing edges that come too close together, and a direction change inside the setup/hold window. Every timing limit is a parameter counted in clock cycles.

Top module: `head_pos_tracker`

## Requirements
- R1: After reset, `track` is 0, the three flags are low, and `trk0_n` is low once a low `sel_n` has passed through the synchroniser.
- R2: A selected step pulse with `dir_n` low (inward), at least MIN_PULSE cycles wide and with write inactive, increments `track` by exactly one. The change appears after the pulse's rising edge; `track` does not move while `step_n` is still low.
- R3: The same step with `dir_n` high (outward) decrements `track` by exactly one.
- R4: A step pulse that is low for fewer than MIN_PULSE cycles leaves `track` unchanged and produces a one-cycle `short_pulse`.
- R5: A step whose trailing edge arrives while `wr_en_n` is low leaves `track` unchanged.
- R6: An outward step at track 0 leaves `track` at 0.
- R7: `track` never exceeds MAX_TRACK; an inward step at MAX_TRACK leaves it there.
- R8: While `sel_n` is high, step pulses leave `track` unchanged and raise no flag.
- R9: `trk0_n` is low exactly when `track` is 0 and the drive is selected; when deselected it is high.
- R10: An accepted-width trailing edge that comes fewer than MIN_INTERVAL cycles after the previous one produces a one-cycle `rate_viol`; the step is still applied.
- R11: A change of `dir_n` within DIR_WIN cycles before a step falling edge, while step is low, or within DIR_WIN cycles after its rising edge produces a one-cycle `dir_viol`.
- R12: Deselecting the drive in the middle of a step pulse sends the state machine to idle, so the pulse's later trailing edge moves nothing and flags nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Drive select, active low |
| step_n | input | 1 | Step pulse, active low |
| dir_n | input | 1 | Direction, low = inward (toward the centre) |
| wr_en_n | input | 1 | Write enable, active low |
| track | output | $clog2(MAX_TRACK+1) | Current track number |
| trk0_n | output | 1 | Track zero, active low, gated by select |
| short_pulse | output | 1 | One-cycle flag: step pulse too short |
| rate_viol | output | 1 | One-cycle flag: step trailing edges too close together |
| dir_viol | output | 1 | One-cycle flag: direction changed inside the setup/hold window |

## Verification
The assertions check the following on every cycle:
- `track` stays within range and moves at most one step per cycle;
- `track` stays still after write has been held active or the drive held deselected for long enough;
- no flag is raised while the drive is deselected;
- the short-pulse and rate flags never fire together;
- `trk0_n` follows the track number and the select line.

The bench scenarios are the only place to show which direction a step takes, whether a particular width is accepted, that motion is held back until the trailing edge, and which setup and hold disturbances raise `dir_viol`. They are also the only way to show the interval check and the abort on mid-pulse deselect.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_HOLD  = 2'd2
    } step_state_t;
endpackage

// File: rtl/hpt_sync_bank.sv
module hpt_sync_bank #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] synced
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic ff1, ff2;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ff1 <= 1'b1;
                ff2 <= 1'b1;
            end else begin
                ff1 <= raw[i];
                ff2 <= ff1;
            end
        end
        assign synced[i] = ff2;
    end
endmodule

// File: rtl/hpt_track_counter.sv
module hpt_track_counter #(
    parameter int MAX_TRACK = 39,
    localparam int TW = $clog2(MAX_TRACK + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          inward,
    output logic [TW-1:0] track,
    output logic          at_zero,
    output logic          at_max
);
    localparam logic [TW-1:0] MAX_T = TW'(MAX_TRACK);

    assign at_zero = (track == '0);
    assign at_max  = (track == MAX_T);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            track <= '0;
        end else if (go) begin
            if (inward && !at_max) begin
                track <= track + 1'b1;
            end else if (!inward && !at_zero) begin
                track <= track - 1'b1;
            end
        end
    end
endmodule

// File: rtl/hpt_step_fsm.sv
module hpt_step_fsm
    import hpt_pkg::*;
#(
    parameter int MIN_PULSE    = 40,
    parameter int DIR_WIN      = 20,
    parameter int MIN_INTERVAL = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_s,
    input  logic step_s,
    input  logic dir_s,
    input  logic wr_s,
    input  logic at_zero,
    input  logic at_max,
    output logic go_o,
    output logic inward_o,
    output logic short_o,
    output logic rate_o,
    output logic dir_o
);
    localparam int PW_W  = $clog2(MIN_PULSE + 1);
    localparam int WIN_W = $clog2(DIR_WIN + 1);
    localparam int GAP_W = $clog2(MIN_INTERVAL + 1);
    localparam logic [PW_W-1:0]  PW_MIN  = PW_W'(MIN_PULSE);
    localparam logic [WIN_W-1:0] WIN_MAX = WIN_W'(DIR_WIN);
    localparam logic [WIN_W-1:0] WIN_END = WIN_W'(DIR_WIN - 1);
    localparam logic [GAP_W-1:0] GAP_MIN = GAP_W'(MIN_INTERVAL);

    step_state_t state, nxt;
    logic             step_p, dir_p;
    logic [PW_W-1:0]  pw_cnt;
    logic [WIN_W-1:0] age_cnt, hold_cnt;
    logic [GAP_W-1:0] gap_cnt;
    logic             have_prev;

    logic fall, rise, dir_chg;
    logic go_n, short_n, rate_n, dirv_n, edge_ok;

    assign fall    = step_p & ~step_s;
    assign rise    = ~step_p & step_s;
    assign dir_chg = dir_s ^ dir_p;

    // next-state and decision logic
    always_comb begin
        nxt     = state;
        go_n    = 1'b0;
        short_n = 1'b0;
        rate_n  = 1'b0;
        dirv_n  = 1'b0;
        edge_ok = 1'b0;
        if (!sel_s) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (fall) begin
                        nxt    = ST_PULSE;
                        dirv_n = dir_chg || (age_cnt < WIN_MAX);
                    end
                end
                ST_PULSE: begin
                    dirv_n = dir_chg;
                    if (rise) begin
                        if (pw_cnt >= PW_MIN) begin
                            edge_ok = 1'b1;
                            go_n    = wr_s && !(dir_s ? at_zero : at_max);
                            rate_n  = have_prev && (gap_cnt < GAP_MIN);
                            nxt     = ST_HOLD;
                        end else begin
                            short_n = 1'b1;
                            nxt     = ST_IDLE;
                        end
                    end
                end
                ST_HOLD: begin
                    dirv_n = dir_chg;
                    if (fall) begin
                        nxt = ST_PULSE;
                    end else if (hold_cnt >= WIN_END) begin
                        nxt = ST_IDLE;
                    end
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // counters and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_p    <= 1'b1;
            dir_p     <= 1'b1;
            pw_cnt    <= '0;
            age_cnt   <= WIN_MAX;
            hold_cnt  <= '0;
            gap_cnt   <= GAP_MIN;
            have_prev <= 1'b0;
            go_o      <= 1'b0;
            inward_o  <= 1'b0;
            short_o   <= 1'b0;
            rate_o    <= 1'b0;
            dir_o     <= 1'b0;
        end else begin
            step_p <= step_s;
            dir_p  <= dir_s;

            if (dir_chg) begin
                age_cnt <= '0;
            end else if (age_cnt < WIN_MAX) begin
                age_cnt <= age_cnt + 1'b1;
            end

            if (fall) begin
                pw_cnt <= PW_W'(1);
            end else if (!step_s && pw_cnt < PW_MIN) begin
                pw_cnt <= pw_cnt + 1'b1;
            end

            if (state != ST_HOLD) begin
                hold_cnt <= '0;
            end else if (hold_cnt < WIN_MAX) begin
                hold_cnt <= hold_cnt + 1'b1;
            end

            if (edge_ok) begin
                gap_cnt   <= GAP_W'(1);
                have_prev <= 1'b1;
            end else if (gap_cnt < GAP_MIN) begin
                gap_cnt <= gap_cnt + 1'b1;
            end

            go_o     <= go_n;
            inward_o <= ~dir_s;
            short_o  <= short_n;
            rate_o   <= rate_n;
            dir_o    <= dirv_n;
        end
    end
endmodule

// File: rtl/head_pos_tracker.sv
module head_pos_tracker #(
    parameter int MAX_TRACK    = 39,
    parameter int MIN_PULSE    = 40,
    parameter int DIR_WIN      = 20,
    parameter int MIN_INTERVAL = 1000000,
    localparam int TW = $clog2(MAX_TRACK + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_n,
    input  logic          step_n,
    input  logic          dir_n,
    input  logic          wr_en_n,
    output logic [TW-1:0] track,
    output logic          trk0_n,
    output logic          short_pulse,
    output logic          rate_viol,
    output logic          dir_viol
);
    logic [3:0] s_bus;
    logic       sel_act, go, inward, at_zero, at_max;

    hpt_sync_bank #(.W(4)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    ({sel_n, step_n, dir_n, wr_en_n}),
        .synced (s_bus)
    );

    assign sel_act = ~s_bus[3];

    hpt_step_fsm #(
        .MIN_PULSE    (MIN_PULSE),
        .DIR_WIN      (DIR_WIN),
        .MIN_INTERVAL (MIN_INTERVAL)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_s    (sel_act),
        .step_s   (s_bus[2]),
        .dir_s    (s_bus[1]),
        .wr_s     (s_bus[0]),
        .at_zero  (at_zero),
        .at_max   (at_max),
        .go_o     (go),
        .inward_o (inward),
        .short_o  (short_pulse),
        .rate_o   (rate_viol),
        .dir_o    (dir_viol)
    );

    hpt_track_counter #(.MAX_TRACK(MAX_TRACK)) u_trk (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go),
        .inward  (inward),
        .track   (track),
        .at_zero (at_zero),
        .at_max  (at_max)
    );

    assign trk0_n = ~(sel_act & at_zero);
endmodule

// File: rtl/hpt_checker.sv
module hpt_checker #(
    parameter int MAX_TRACK = 39,
    localparam int TW = $clog2(MAX_TRACK + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sel_n,
    input logic          wr_en_n,
    input logic [TW-1:0] track,
    input logic          trk0_n,
    input logic          short_pulse,
    input logic          rate_viol,
    input logic          dir_viol
);
    localparam logic [TW-1:0] MAX_T = TW'(MAX_TRACK);

    logic [2:0] wr_run, desel_run, sel_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_run    <= '0;
            desel_run <= '0;
            sel_run   <= '0;
        end else begin
            wr_run    <= wr_en_n ? 3'd0 : ((wr_run == 3'd7) ? wr_run : wr_run + 3'd1);
            desel_run <= !sel_n  ? 3'd0 : ((desel_run == 3'd7) ? desel_run : desel_run + 3'd1);
            sel_run   <= sel_n   ? 3'd0 : ((sel_run == 3'd7) ? sel_run : sel_run + 3'd1);
        end
    end

    assert_track_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        track <= MAX_T);

    assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (track != $past(track)) |-> ((track == $past(track) + 1'b1) || ($past(track) == track + 1'b1)));

    assert_write_freezes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_run >= 3'd4) |-> $stable(track));

    assert_desel_freezes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (desel_run >= 3'd4) |-> ($stable(track) && !short_pulse && !rate_viol && !dir_viol));

    assert_flags_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({short_pulse, rate_viol}));

    assert_trk0_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (track != '0) |-> trk0_n);

    assert_trk0_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel_run >= 3'd3) && (track == '0)) |-> !trk0_n);
endmodule

bind head_pos_tracker hpt_checker #(.MAX_TRACK(MAX_TRACK)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_n       (sel_n),
    .wr_en_n     (wr_en_n),
    .track       (track),
    .trk0_n      (trk0_n),
    .short_pulse (short_pulse),
    .rate_viol   (rate_viol),
    .dir_viol    (dir_viol)
);

// File: tb/sim_head_pos_tracker.sv
`timescale 1ns/1ps
module sim_head_pos_tracker;
    localparam int MAXT = 7;
    localparam int MINP = 4;
    localparam int WIN  = 3;
    localparam int GAP  = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_n = 1'b0;
    logic       step_n = 1'b1;
    logic       dir_n = 1'b1;
    logic       wr_en_n = 1'b1;
    logic [2:0] track;
    logic       trk0_n, short_pulse, rate_viol, dir_viol;

    int checks = 0;
    int errors = 0;
    int n_short = 0, n_rate = 0, n_dir = 0;
    int exp_track = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    head_pos_tracker #(
        .MAX_TRACK(MAXT), .MIN_PULSE(MINP), .DIR_WIN(WIN), .MIN_INTERVAL(GAP)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .step_n(step_n), .dir_n(dir_n),
        .wr_en_n(wr_en_n), .track(track), .trk0_n(trk0_n),
        .short_pulse(short_pulse), .rate_viol(rate_viol), .dir_viol(dir_viol)
    );

    always @(posedge clk) begin
        if (short_pulse) n_short++;
        if (rate_viol)   n_rate++;
        if (dir_viol)    n_dir++;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one step: direction setup, pulse of w cycles, hold, then extra gap
    task automatic do_step(input bit inward, input int w, input int gap);
        @(negedge clk) dir_n = inward ? 1'b0 : 1'b1;
        repeat (5) @(negedge clk);
        step_n = 1'b0;
        repeat (w) @(negedge clk);
        step_n = 1'b1;
        repeat (6) @(negedge clk);
        repeat (gap) @(negedge clk);
    endtask

    function automatic int model(input int cur, input bit inward, input int w, input bit wr, input bit sel);
        if (!sel || w < MINP || wr) return cur;
        if (inward) return (cur < MAXT) ? cur + 1 : cur;
        return (cur > 0) ? cur - 1 : cur;
    endfunction

    initial begin
        int s0, r0, d0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 track", int'(track), 0);
        chk("R1 trk0_n", int'(trk0_n), 0);
        chk("R1 flags", int'({short_pulse, rate_viol, dir_viol}), 0);

        // R6: outward at track 0
        do_step(1'b0, MINP, GAP);
        chk("R6 outward at zero", int'(track), 0);

        // R2/R7/R9: inward sweep past the end
        for (int i = 0; i < MAXT + 3; i++) begin
            exp_track = model(exp_track, 1'b1, MINP + (i % 3), 1'b0, 1'b1);
            do_step(1'b1, MINP + (i % 3), GAP);
            chk("R2 R7 inward sweep", int'(track), exp_track);
            chk("R9 trk0_n", int'(trk0_n), (exp_track == 0) ? 0 : 1);
        end

        // R3/R6: outward sweep past zero
        for (int i = 0; i < MAXT + 3; i++) begin
            exp_track = model(exp_track, 1'b0, MINP, 1'b0, 1'b1);
            do_step(1'b0, MINP, GAP);
            chk("R3 R6 outward sweep", int'(track), exp_track);
            chk("R9 trk0_n", int'(trk0_n), (exp_track == 0) ? 0 : 1);
        end

        // R4: width sweep, inward
        for (int w = 1; w <= MINP + 2; w++) begin
            s0 = n_short;
            exp_track = model(exp_track, 1'b1, w, 1'b0, 1'b1);
            do_step(1'b1, w, GAP);
            chk("R4 width track", int'(track), exp_track);
            chk("R4 short flag", n_short - s0, (w < MINP) ? 1 : 0);
        end

        // R2: no motion while step still low
        @(negedge clk) dir_n = 1'b1;
        repeat (5) @(negedge clk);
        step_n = 1'b0;
        repeat (10) @(negedge clk);
        chk("R2 held low no move", int'(track), exp_track);
        step_n = 1'b1;
        exp_track = model(exp_track, 1'b0, 10, 1'b0, 1'b1);
        repeat (6 + GAP) @(negedge clk);
        chk("R2 R3 move after trailing edge", int'(track), exp_track);

        // R5: write active blocks both directions
        wr_en_n = 1'b0;
        do_step(1'b1, MINP, GAP);
        chk("R5 write blocks inward", int'(track), exp_track);
        do_step(1'b0, MINP, GAP);
        chk("R5 write blocks outward", int'(track), exp_track);
        wr_en_n = 1'b1;

        // R8/R9: deselected
        @(negedge clk) sel_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R9 trk0_n deselected", int'(trk0_n), 1);
        s0 = n_short; r0 = n_rate; d0 = n_dir;
        do_step(1'b1, MINP, 0);
        do_step(1'b1, 1, 0);
        chk("R8 deselected track", int'(track), exp_track);
        chk("R8 deselected flags", (n_short - s0) + (n_rate - r0) + (n_dir - d0), 0);
        @(negedge clk) sel_n = 1'b0;
        repeat (GAP) @(negedge clk);

        // R12: deselect mid-pulse
        s0 = n_short;
        @(negedge clk) dir_n = 1'b0;
        repeat (5) @(negedge clk);
        step_n = 1'b0;
        repeat (6) @(negedge clk);
        sel_n = 1'b1;
        repeat (4) @(negedge clk);
        step_n = 1'b1;
        repeat (6) @(negedge clk);
        sel_n = 1'b0;
        repeat (GAP) @(negedge clk);
        chk("R12 abort track", int'(track), exp_track);
        chk("R12 abort flags", n_short - s0, 0);

        // R10: close trailing edges, step still applied
        r0 = n_rate;
        exp_track = model(exp_track, 1'b1, MINP, 1'b0, 1'b1);
        do_step(1'b1, MINP, 0);
        exp_track = model(exp_track, 1'b1, MINP, 1'b0, 1'b1);
        do_step(1'b1, MINP, GAP);
        chk("R10 rate flag", n_rate - r0, 1);
        chk("R10 step applied", int'(track), exp_track);
        r0 = n_rate;
        do_step(1'b1, MINP, GAP);
        exp_track = model(exp_track, 1'b1, MINP, 1'b0, 1'b1);
        chk("R10 spaced no flag", n_rate - r0, 0);

        // R11: clean step gives no direction flag
        d0 = n_dir;
        exp_track = model(exp_track, 1'b0, MINP, 1'b0, 1'b1);
        do_step(1'b0, MINP, GAP);
        chk("R11 clean no flag", n_dir - d0, 0);

        // R11: setup violation (direction flips one cycle before step)
        d0 = n_dir;
        @(negedge clk) dir_n = 1'b0;
        @(negedge clk) step_n = 1'b0;
        repeat (MINP) @(negedge clk);
        step_n = 1'b1;
        repeat (6 + GAP) @(negedge clk);
        exp_track = model(exp_track, 1'b1, MINP, 1'b0, 1'b1);
        chk("R11 setup flag", n_dir - d0, 1);
        chk("R11 setup step moves", int'(track), exp_track);

        // R11: change during pulse
        d0 = n_dir;
        repeat (5) @(negedge clk);
        step_n = 1'b0;
        repeat (2) @(negedge clk);
        dir_n = 1'b1;
        repeat (4) @(negedge clk);
        step_n = 1'b1;
        repeat (6 + GAP) @(negedge clk);
        exp_track = model(exp_track, 1'b0, 6, 1'b0, 1'b1);
        chk("R11 mid-pulse flag", n_dir - d0, 1);

        // R11: hold violation
        d0 = n_dir;
        repeat (5) @(negedge clk);
        step_n = 1'b0;
        repeat (MINP) @(negedge clk);
        step_n = 1'b1;
        @(negedge clk) dir_n = 1'b0;
        repeat (6 + GAP) @(negedge clk);
        exp_track = model(exp_track, 1'b0, MINP, 1'b0, 1'b1);
        chk("R11 hold flag", n_dir - d0, 1);
        chk("R11 hold step moves", int'(track), exp_track);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule